// File: doc/BRIEF.md
# Cell Boundary Delineator

This block recovers the boundaries of fixed-length 424-bit cells from a serial received bit stream. It slides a 40-bit window across the stream and tests whether the window is a valid header. A window is valid when it divides evenly by the check polynomial x^8 + x^2 + x + 1, meaning its last 8 bits are the CRC of its first 32 bits. A three-state machine (hunt, presync, sync) acquires alignment bit by bit. It confirms alignment over several consecutive cells, and it gives alignment up only after a run of consecutive bad headers. This hysteresis stops isolated bit errors from causing loss of alignment.

A line-side receiver feeds the block one bit per strobe. Downstream cell logic uses the one-cycle cell-start pulse and the captured 40-bit header to frame each cell while the block is in sync. Correction of header errors and buffering of payload bytes are left to other blocks.

Top module: `cell_delineator`

## Requirements
- R1: While `bit_vld` is low, `bit_in` is ignored: neither the header window nor the position within the cell advances, so gaps in the strobe do not change any result.
- R2: After reset, `state` is HUNT (code 0), `cell_start` is 0 and `hdr_out` is 0.
- R3: In HUNT, once 40 valid bits have arrived since reset or since `rx_fail`, every valid bit tests the last 40 bits. The first-received bit is the highest-order coefficient. A zero remainder modulo x^8 + x^2 + x + 1 moves `state` to PRESYNC (code 1) on that same clock edge.
- R4: In PRESYNC, a header is tested only when the last of its 40 bits arrives, exactly 424 valid bits after the previous tested header end. DELTA (default 6) consecutive zero remainders move `state` to SYNC (code 2).
- R5: In PRESYNC, one tested header with a nonzero remainder returns `state` to HUNT.
- R6: In SYNC, every tested header produces a one-cycle `cell_start` pulse, starting on the clock edge that accepts its 40th bit. With the pulse, `hdr_out` holds that header with its first-received bit in bit 39. This includes the header that causes loss of sync. No pulse occurs outside SYNC.
- R7: In SYNC, ALPHA (default 7) consecutive headers with nonzero remainder return `state` to HUNT. ALPHA-1 consecutive bad headers leave it in SYNC.
- R8: A good header tested in SYNC clears the count of consecutive bad headers.
- R9: `rx_fail` high forces `state` to HUNT on the next edge. It also restarts the 40-bit fill count of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_fail | input | 1 | Receiver failure, forces hunt |
| bit_in | input | 1 | Serial received bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| state | output | 2 | 0 hunt, 1 presync, 2 sync |
| cell_start | output | 1 | One-cycle pulse per header tested in sync |
| hdr_out | output | HDR_BITS | Last header tested in sync, first bit in MSB |

## Verification
A wrong bit position counter shows at the ports at the first tested header after presync entry. It either falls back to hunt or moves a `cell_start` pulse away from the 424-bit grid, and both are checked at every header end. A wrong hysteresis count shows as a state change one header early or late. Such an error appears within at most DELTA or ALPHA cells of the stimulus that exercises it. A fill counter that is not honoured is caught within 40 bits of reset or `rx_fail`, because an all-zero window would then be accepted too early.

// File: rtl/cd_pkg.sv
package cd_pkg;
   typedef enum logic [1:0] {
      ST_HUNT    = 2'd0,
      ST_PRESYNC = 2'd1,
      ST_SYNC    = 2'd2
   } cd_state_e;
endpackage

// File: rtl/cd_window.sv
// Sliding header window with a parallel remainder tree built from x^i mod g.
module cd_window #(
   parameter int unsigned HDR_BITS = 40,
   parameter int unsigned CRC_BITS = 8,
   parameter logic [CRC_BITS-1:0] POLY = 8'h07
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                bit_in,
   input  logic                bit_vld,
   output logic [HDR_BITS-1:0] win_nxt,
   output logic                syn_zero,
   output logic                full
);
   localparam int unsigned FW = $clog2(HDR_BITS);
   localparam logic [FW-1:0] FILL_MAX = FW'(HDR_BITS - 1);

   logic [HDR_BITS-1:0] win_q;
   logic [FW-1:0]       fill_q;

   function automatic logic [CRC_BITS-1:0] xpow_mod(input int unsigned n);
      logic [CRC_BITS-1:0] r;
      logic                top;
      r = CRC_BITS'(1);
      for (int unsigned s = 0; s < n; s++) begin
         top = r[CRC_BITS-1];
         r   = r << 1;
         if (top) r = r ^ POLY;
      end
      return r;
   endfunction

   assign win_nxt = {win_q[HDR_BITS-2:0], bit_in};
   assign full    = (fill_q == FILL_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q  <= '0;
         fill_q <= '0;
      end else if (clr) begin
         fill_q <= '0;
      end else if (bit_vld) begin
         win_q <= win_nxt;
         if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
      end
   end

   logic [CRC_BITS-1:0] term [HDR_BITS];
   logic [CRC_BITS-1:0] syn;

   generate
      for (genvar i = 0; i < HDR_BITS; i++) begin : g_term
         localparam logic [CRC_BITS-1:0] R_I = xpow_mod(i);
         assign term[i] = win_nxt[i] ? R_I : '0;
      end
   endgenerate

   always_comb begin
      syn = '0;
      for (int k = 0; k < HDR_BITS; k++) syn = syn ^ term[k];
   end

   assign syn_zero = (syn == '0);

   // R1: an idle strobe leaves the window untouched
   a_r1_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_vld && !clr) |=> $stable(win_q));
endmodule

// File: rtl/cd_pos_counter.sv
// Bit position within a cell, counted in valid bits only.
module cd_pos_counter #(
   parameter int unsigned CELL_BITS = 424
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic bit_vld,
   output logic at_last
);
   localparam int unsigned CW = $clog2(CELL_BITS);
   localparam logic [CW-1:0] LAST = CW'(CELL_BITS - 1);

   logic [CW-1:0] cnt_q;

   assign at_last = (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (bit_vld) begin
         if (restart || at_last) cnt_q <= '0;
         else                    cnt_q <= cnt_q + 1'b1;
      end
   end

   // R1: position does not move without a valid bit
   a_r1_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_vld |=> $stable(cnt_q));
endmodule

// File: rtl/cd_fsm.sv
// Hunt / presync / sync control with acquire and loss hysteresis.
module cd_fsm
   import cd_pkg::*;
#(
   parameter int unsigned DELTA = 6,
   parameter int unsigned ALPHA = 7
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      rx_fail,
   input  logic      bit_vld,
   input  logic      full,
   input  logic      at_last,
   input  logic      syn_zero,
   output cd_state_e state,
   output logic      restart,
   output logic      take
);
   localparam int unsigned MW = $clog2(DELTA + 1);
   localparam int unsigned LW = $clog2(ALPHA + 1);
   localparam logic [MW-1:0] MATCH_LAST = MW'(DELTA - 1);
   localparam logic [LW-1:0] MISS_LAST  = LW'(ALPHA - 1);

   cd_state_e     state_q;
   logic [MW-1:0] match_q;
   logic [LW-1:0] miss_q;
   logic          chk;

   assign state   = state_q;
   assign chk     = bit_vld && ((state_q == ST_HUNT) ? full : at_last);
   assign restart = (state_q == ST_HUNT) && chk && syn_zero;
   assign take    = (state_q == ST_SYNC) && chk;

   always_ff @(posedge clk) begin
      if (!rst_n || rx_fail) begin
         state_q <= ST_HUNT;
         match_q <= '0;
         miss_q  <= '0;
      end else if (chk) begin
         unique case (state_q)
            ST_HUNT: begin
               if (syn_zero) begin
                  state_q <= ST_PRESYNC;
                  match_q <= '0;
               end
            end
            ST_PRESYNC: begin
               if (!syn_zero) begin
                  state_q <= ST_HUNT;
               end else if (match_q == MATCH_LAST) begin
                  state_q <= ST_SYNC;
                  miss_q  <= '0;
               end else begin
                  match_q <= match_q + 1'b1;
               end
            end
            ST_SYNC: begin
               if (syn_zero) begin
                  miss_q <= '0;
               end else if (miss_q == MISS_LAST) begin
                  state_q <= ST_HUNT;
                  miss_q  <= '0;
               end else begin
                  miss_q <= miss_q + 1'b1;
               end
            end
            default: state_q <= ST_HUNT;
         endcase
      end
   end

   a_r3_hunt_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HUNT && bit_vld && full && syn_zero && !rx_fail) |=> state_q == ST_PRESYNC);
   a_r4_enter_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PRESYNC && chk && syn_zero && match_q == MATCH_LAST && !rx_fail)
      |=> state_q == ST_SYNC);
   a_r5_presync_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PRESYNC && chk && !syn_zero) |=> state_q == ST_HUNT);
   a_r7_lose_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SYNC && chk && !syn_zero && miss_q == MISS_LAST) |=> state_q == ST_HUNT);
   a_r8_good_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SYNC && chk && syn_zero && !rx_fail) |=> (state_q == ST_SYNC && miss_q == '0));
   a_r9_fail_hunt: assert property (@(posedge clk) disable iff (!rst_n)
      rx_fail |=> state_q == ST_HUNT);
endmodule

// File: rtl/cell_delineator.sv
module cell_delineator
   import cd_pkg::*;
#(
   parameter int unsigned CELL_BITS = 424,
   parameter int unsigned HDR_BITS  = 40,
   parameter int unsigned CRC_BITS  = 8,
   parameter logic [CRC_BITS-1:0] POLY = 8'h07,
   parameter int unsigned DELTA     = 6,
   parameter int unsigned ALPHA     = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_fail,
   input  logic                bit_in,
   input  logic                bit_vld,
   output logic [1:0]          state,
   output logic                cell_start,
   output logic [HDR_BITS-1:0] hdr_out
);
   generate
      if (HDR_BITS <= CRC_BITS) begin : g_bad_hdr
         $error("HDR_BITS must exceed CRC_BITS");
      end
      if (CELL_BITS <= HDR_BITS) begin : g_bad_cell
         $error("CELL_BITS must exceed HDR_BITS");
      end
      if (DELTA < 1 || ALPHA < 1) begin : g_bad_hyst
         $error("DELTA and ALPHA must be at least 1");
      end
   endgenerate

   logic [HDR_BITS-1:0] win_nxt;
   logic                syn_zero, full, at_last, restart, take;
   cd_state_e           st;

   cd_window #(.HDR_BITS(HDR_BITS), .CRC_BITS(CRC_BITS), .POLY(POLY)) u_win (
      .clk(clk), .rst_n(rst_n), .clr(rx_fail), .bit_in(bit_in), .bit_vld(bit_vld),
      .win_nxt(win_nxt), .syn_zero(syn_zero), .full(full));

   cd_pos_counter #(.CELL_BITS(CELL_BITS)) u_pos (
      .clk(clk), .rst_n(rst_n), .restart(restart), .bit_vld(bit_vld), .at_last(at_last));

   cd_fsm #(.DELTA(DELTA), .ALPHA(ALPHA)) u_fsm (
      .clk(clk), .rst_n(rst_n), .rx_fail(rx_fail), .bit_vld(bit_vld), .full(full),
      .at_last(at_last), .syn_zero(syn_zero), .state(st), .restart(restart), .take(take));

   assign state = st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cell_start <= 1'b0;
         hdr_out    <= '0;
      end else begin
         cell_start <= take && !rx_fail;
         if (take && !rx_fail) hdr_out <= win_nxt;
      end
   end

   // R6: a pulse only follows a cycle spent in sync
   a_r6_pulse_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
      cell_start |-> $past(st) == ST_SYNC);
   a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      cell_start |=> !cell_start);
endmodule

// File: tb/tb_cell_delineator.sv
`timescale 1ns/1ps
module tb_cell_delineator;
   localparam int CELL  = 424;
   localparam int HB    = 40;
   localparam int DELTA = 6;
   localparam int ALPHA = 7;
   localparam int NMAX  = 16384;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_fail = 1'b0;
   logic bit_in = 1'b0;
   logic bit_vld = 1'b0;
   logic [1:0] state;
   logic cell_start;
   logic [HB-1:0] hdr_out;

   always #2.5 clk = ~clk;

   cell_delineator dut (.clk(clk), .rst_n(rst_n), .rx_fail(rx_fail), .bit_in(bit_in),
      .bit_vld(bit_vld), .state(state), .cell_start(cell_start), .hdr_out(hdr_out));

   int n_chk = 0;
   int n_fail = 0;
   bit stream [NMAX];
   int exp_st [NMAX];
   bit exp_cs [NMAX];
   logic [HB-1:0] exp_hdr [NMAX];
   int unsigned lcg;

   task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] rem_of(logic [HB-1:0] w, int nbits);
      logic [7:0] r = 8'h00;
      for (int j = nbits - 1; j >= 0; j--) begin
         logic fb = r[7] ^ w[j];
         r = {r[6:0], 1'b0};
         if (fb) r = r ^ 8'h07;
      end
      return r;
   endfunction

   function automatic bit next_bit();
      lcg = lcg * 32'd1103515245 + 32'd12345;
      return lcg[16];
   endfunction

   function automatic logic [HB-1:0] win_at(int p);
      logic [HB-1:0] w;
      for (int j = 0; j < HB; j++) w[HB-1-j] = stream[p-HB+1+j];
      return w;
   endfunction

   task automatic build(int prefix, int ncells, int unsigned seed);
      int pos = 0;
      lcg = seed;
      for (int i = 0; i < prefix; i++) begin stream[pos] = next_bit(); pos++; end
      for (int k = 0; k < ncells; k++) begin
         logic [31:0] h = {8'h5A ^ 8'(k), 8'(8'h10 + k), 8'hC3, 8'(8'h01 + k)};
         logic [HB-1:0] cw = {h, rem_of({8'h00, h}, 32)};
         for (int j = HB - 1; j >= 0; j--) begin stream[pos] = cw[j]; pos++; end
         for (int j = 0; j < CELL - HB; j++) begin stream[pos] = next_bit(); pos++; end
      end
   endtask

   // rebuild until no window before the true first header matches
   task automatic make_clean(int prefix, int ncells);
      for (int s = 1; s < 400; s++) begin
         int hit = -1;
         build(prefix, ncells, s * 7919);
         for (int p = HB - 1; p <= prefix + HB - 1 && hit < 0; p++)
            if (rem_of(win_at(p), HB) == 8'h00) hit = p;
         if (hit == prefix + HB - 1) return;
      end
      $display("FAIL setup no clean stream actual=0 expected=1");
      n_fail++;
   endtask

   function automatic int hend(int prefix, int k);
      return prefix + HB - 1 + k * CELL;
   endfunction

   task automatic clear_exp();
      for (int i = 0; i < NMAX; i++) begin exp_st[i] = -1; exp_cs[i] = 1'b0; end
   endtask

   task automatic set_exp(int prefix, int k, int st, bit cs);
      int i = hend(prefix, k);
      exp_st[i]  = st;
      exp_cs[i]  = cs;
      exp_hdr[i] = win_at(i);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bit_vld = 1'b0; rx_fail = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic send(bit b);
      @(negedge clk);
      bit_in = b; bit_vld = 1'b1;
      @(posedge clk);
      #1;
   endtask

   task automatic drive(int n, int gap, string req);
      int stray = 0;
      for (int i = 0; i < n; i++) begin
         if (gap > 0 && (i % gap) == gap - 1) begin
            repeat (2) begin
               @(negedge clk);
               bit_vld = 1'b0; bit_in = ~bit_in;
               @(posedge clk); #1;
               if (cell_start) stray++;
            end
         end
         send(stream[i]);
         if (exp_st[i] >= 0) begin
            check_eq(req, $sformatf("state at bit %0d", i), 64'(state), 64'(exp_st[i]));
            check_eq("R6", $sformatf("cell_start at bit %0d", i), 64'(cell_start), 64'(exp_cs[i]));
            if (exp_cs[i]) check_eq("R6", $sformatf("hdr_out at bit %0d", i), 64'(hdr_out), 64'(exp_hdr[i]));
         end else if (cell_start) begin
            stray++;
         end
      end
      @(negedge clk);
      bit_vld = 1'b0;
      check_eq("R6", "pulses off the header grid", 64'(stray), 64'd0);
   endtask

   task automatic t_reset_r2();
      do_reset();
      @(posedge clk); #1;
      check_eq("R2", "state after reset", 64'(state), 64'd0);
      check_eq("R2", "cell_start after reset", 64'(cell_start), 64'd0);
      check_eq("R2", "hdr_out after reset", 64'(hdr_out), 64'd0);
   endtask

   task automatic t_fill_r3();
      do_reset();
      for (int i = 0; i < HB - 1; i++) send(1'b0);
      check_eq("R3", "state before 40 bits", 64'(state), 64'd0);
      send(1'b0);
      check_eq("R3", "state after 40th zero bit", 64'(state), 64'd1);
      @(negedge clk); bit_vld = 1'b0;
   endtask

   task automatic acquire_exp(int prefix, int ncells);
      clear_exp();
      exp_st[hend(prefix, 0) - 1] = 0;
      for (int k = 0; k < ncells; k++) begin
         if (k < DELTA) set_exp(prefix, k, 1, 1'b0);
         else if (k == DELTA) set_exp(prefix, k, 2, 1'b0);
         else set_exp(prefix, k, 2, 1'b1);
      end
   endtask

   task automatic t_acquire_r4();
      make_clean(0, 10);
      acquire_exp(0, 10);
      do_reset();
      drive(hend(0, 9) + 1, 0, "R4");
   endtask

   task automatic t_offset_gaps_r1();
      make_clean(137, 9);
      acquire_exp(137, 9);
      do_reset();
      drive(hend(137, 8) + 1, 5, "R1");
   endtask

   task automatic t_presync_miss_r5();
      make_clean(51, 5);
      stream[51 + 3 * CELL + 3] = ~stream[51 + 3 * CELL + 3];
      clear_exp();
      for (int k = 0; k < 3; k++) set_exp(51, k, 1, 1'b0);
      set_exp(51, 3, 0, 1'b0);
      do_reset();
      drive(hend(51, 3) + 1, 0, "R5");
   endtask

   task automatic t_sync_loss_r7();
      make_clean(20, 23);
      for (int k = 8; k <= 21; k++)
         if (k != 14) stream[20 + k * CELL + 5] = ~stream[20 + k * CELL + 5];
      acquire_exp(20, 22);
      for (int k = 8; k <= 13; k++) set_exp(20, k, 2, 1'b1);   // R7: ALPHA-1 bad keeps sync
      set_exp(20, 14, 2, 1'b1);                                // R8: good header clears count
      for (int k = 15; k <= 20; k++) set_exp(20, k, 2, 1'b1);
      set_exp(20, 21, 0, 1'b1);                                // R7: ALPHA-th bad -> hunt
      do_reset();
      drive(hend(20, 21) + 1, 0, "R7");
   endtask

   task automatic t_rx_fail_r9();
      make_clean(0, 9);
      acquire_exp(0, 8);
      do_reset();
      drive(hend(0, 7) + 1, 0, "R9");
      check_eq("R9", "in sync before fail", 64'(state), 64'd2);
      @(negedge clk); rx_fail = 1'b1;
      @(posedge clk); #1;
      check_eq("R9", "state after rx_fail", 64'(state), 64'd0);
      @(negedge clk); rx_fail = 1'b0;
      for (int i = 0; i < HB - 1; i++) send(1'b0);
      check_eq("R9", "fill restarted after rx_fail", 64'(state), 64'd0);
      send(1'b0);
      check_eq("R9", "hunt hit after refill", 64'(state), 64'd1);
      @(negedge clk); bit_vld = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset_r2();
      t_fill_r3();
      t_acquire_r4();
      t_offset_gaps_r1();
      t_presync_miss_r5();
      t_sync_loss_r7();
      t_rx_fail_r9();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule